// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block manages the receive side of a network controller through a small circular ring of buffer descriptors kept in an internal register file. Each descriptor has three 32-bit words: a link to the next descriptor, a command/status word, and a buffer pointer. The host gives a descriptor to the engine by writing the buffer size into the command/status word with the ownership flag (bit 31) clear. When a frame finishes, the engine writes the length and status into the descriptor it is working on. It then sets the ownership flag, which hands the descriptor back to the host, and moves to the descriptor that the link word names.

The engine stops by itself when it reaches a descriptor the host has not yet returned. From that point it drops every completed frame and signals each drop with a missed-frame pulse. It stays stopped until the host sends a receive-on command. A receive-off command stops it at any time. Moving payload bytes to memory, framing, and interrupt delivery are handled by other blocks.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the engine is stopped (`run_o`=0) and the current index is 0. Descriptor i has link = (i+1) mod 4, command/status = 1536 (0x600) with bit 31 clear, and buffer pointer = i*1536.
- R2: The host port selects a descriptor with `host_idx_i` and a word with `host_word_i`: 0 is link, 1 is command/status, 2 is buffer pointer. Word 3 always reads 0, and writes to word 3 change nothing.
- R3: A pulse on `rx_on_i` starts the engine. A pulse on `rx_off_i` stops it. When both pulse in the same cycle, stop wins. `run_o` reflects the command in the cycle after it.
- R4: A frame is accepted when `frm_done_i` is high, the engine is running, and bit 31 of the current descriptor is clear. The engine then writes bit 31 = 1 and bits 11:0 = frame length (CRC included), and pulses `desc_done_o` in the next cycle.
- R5: The written status holds three flags. Bit 30 copies `frm_more_i`. Bit 29 keeps the value the host wrote. Bit 27 (good) is 1 only when `frm_err_i` is 0 and the frame is not too long.
- R6: When the frame length exceeds the size in bits 11:0 of the descriptor, the engine sets bit 22, clears bit 27, and writes the length as that size.
- R7: After an accepted frame, the current index becomes the low index bits of the descriptor's link word. This wraps the default ring from 3 to 0 and follows any link the host has written.
- R8: When the engine is running and the current descriptor has bit 31 set, the engine stops one cycle later. A frame that arrives in that cycle is dropped: no descriptor changes and `missed_o` pulses.
- R9: A frame that completes while the engine is stopped is dropped. `missed_o` pulses in the next cycle, no descriptor changes, and the index stays the same.
- R10: After the host returns the current descriptor and sends receive-on, the engine continues at the same index.
- R11: When the host writes a command/status word in the same cycle that the engine writes the same word, the engine's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_idx_i | input | 2 | Descriptor index for host access |
| host_word_i | input | 2 | Word select: 0 link, 1 cmd/status, 2 buffer pointer |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data (combinational) |
| rx_on_i | input | 1 | Receive-on command pulse |
| rx_off_i | input | 1 | Receive-off command pulse |
| frm_done_i | input | 1 | Frame completion strobe |
| frm_len_i | input | 16 | Received length in bytes, CRC included |
| frm_err_i | input | 1 | Frame had an error |
| frm_more_i | input | 1 | More fragments follow |
| run_o | output | 1 | Engine is running |
| cur_idx_o | output | 2 | Current descriptor index |
| desc_done_o | output | 1 | Pulse: a descriptor was completed |
| missed_o | output | 1 | Pulse: a frame was dropped |

## Verification
The completion path is exercised with four kinds of frame: a clean frame, a frame with an error flag, a fragment frame, and frames longer than the buffer. Comparing their results shows that the good, more and too-long bits are each driven by their own condition, and that the clamp uses the size the host wrote, not a fixed limit. Frames are also sent while the engine is stopped, while it is stalled on an owned descriptor, and after receive-off. These cases show that a frame is dropped only because of the run state and the ownership flag. Custom link values and a host write in the same cycle as a completion check that the ring follows the link words and that the engine's write takes priority.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SIZE_W    = 12;
  localparam int unsigned BUF_BYTES = 1536;
  // command/status bit positions
  localparam int unsigned OWN_B  = 31;
  localparam int unsigned MORE_B = 30;
  localparam int unsigned INTR_B = 29;
  localparam int unsigned OK_B   = 27;
  localparam int unsigned LONG_B = 22;
  typedef enum logic [1:0] {W_LINK = 2'd0, W_CMD = 2'd1, W_BUF = 2'd2, W_NONE = 2'd3} word_sel_e;
endpackage

// File: rtl/rx_desc_file.sv
module rx_desc_file
  import rx_ring_pkg::*;
#(
  parameter int unsigned N_DESC = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [IDX_W-1:0]  host_idx_i,
  input  logic [1:0]        host_word_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  input  logic              eng_we_i,
  input  logic [IDX_W-1:0]  eng_idx_i,
  input  logic [WORD_W-1:0] eng_cmdsts_i,
  input  logic [IDX_W-1:0]  cur_idx_i,
  output logic [IDX_W-1:0]  cur_link_o,
  output logic              cur_own_o,
  output logic              cur_intr_o,
  output logic [SIZE_W-1:0] cur_size_o
);
  logic [WORD_W-1:0] link_q [N_DESC];
  logic [WORD_W-1:0] cmd_q  [N_DESC];
  logic [WORD_W-1:0] buf_q  [N_DESC];

  for (genvar g = 0; g < N_DESC; g++) begin : g_desc
    localparam logic [WORD_W-1:0] LINK_RST = WORD_W'((g + 1) % N_DESC);
    localparam logic [WORD_W-1:0] BUF_RST  = WORD_W'(g * BUF_BYTES);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        link_q[g] <= LINK_RST;
        cmd_q[g]  <= WORD_W'(BUF_BYTES);
        buf_q[g]  <= BUF_RST;
      end else begin
        if (host_we_i && host_idx_i == IDX_W'(g)) begin
          case (word_sel_e'(host_word_i))
            W_LINK:  link_q[g] <= host_wdata_i;
            W_CMD:   cmd_q[g]  <= host_wdata_i;
            W_BUF:   buf_q[g]  <= host_wdata_i;
            default: ;
          endcase
        end
        // engine completion overrides a same-cycle host write
        if (eng_we_i && eng_idx_i == IDX_W'(g)) cmd_q[g] <= eng_cmdsts_i;
      end
    end
  end

  always_comb begin
    case (word_sel_e'(host_word_i))
      W_LINK:  host_rdata_o = link_q[host_idx_i];
      W_CMD:   host_rdata_o = cmd_q[host_idx_i];
      W_BUF:   host_rdata_o = buf_q[host_idx_i];
      default: host_rdata_o = '0;
    endcase
  end

  assign cur_link_o = link_q[cur_idx_i][IDX_W-1:0];
  assign cur_own_o  = cmd_q[cur_idx_i][OWN_B];
  assign cur_intr_o = cmd_q[cur_idx_i][INTR_B];
  assign cur_size_o = cmd_q[cur_idx_i][SIZE_W-1:0];

  a_r4_own_returned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we_i |=> cmd_q[$past(eng_idx_i)][OWN_B]);
  a_r11_engine_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_we_i && host_we_i && host_word_i == 2'd1 && host_idx_i == eng_idx_i)
      |=> cmd_q[$past(eng_idx_i)] == $past(eng_cmdsts_i));
  a_r6_len_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we_i |-> eng_cmdsts_i[SIZE_W-1:0] <= cmd_q[eng_idx_i][SIZE_W-1:0]);
  a_r6_long_not_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_we_i && eng_cmdsts_i[LONG_B]) |-> !eng_cmdsts_i[OK_B]);
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int unsigned IDX_W = 2,
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_on_i,
  input  logic              rx_off_i,
  input  logic              frm_done_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  input  logic              frm_err_i,
  input  logic              frm_more_i,
  input  logic [IDX_W-1:0]  cur_link_i,
  input  logic              cur_own_i,
  input  logic              cur_intr_i,
  input  logic [SIZE_W-1:0] cur_size_i,
  output logic [IDX_W-1:0]  cur_idx_o,
  output logic              eng_we_o,
  output logic [WORD_W-1:0] eng_cmdsts_o,
  output logic              run_o,
  output logic              desc_done_o,
  output logic              missed_o
);
  logic             run_q, done_q, missed_q;
  logic [IDX_W-1:0] idx_q;
  logic             accept, too_long;

  assign accept   = frm_done_i && run_q && !cur_own_i;
  assign too_long = frm_len_i > LEN_W'(cur_size_i);

  always_comb begin
    eng_cmdsts_o               = '0;
    eng_cmdsts_o[OWN_B]        = 1'b1;
    eng_cmdsts_o[MORE_B]       = frm_more_i;
    eng_cmdsts_o[INTR_B]       = cur_intr_i;
    eng_cmdsts_o[OK_B]         = !frm_err_i && !too_long;
    eng_cmdsts_o[LONG_B]       = too_long;
    eng_cmdsts_o[SIZE_W-1:0]   = too_long ? cur_size_i : frm_len_i[SIZE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      missed_q <= 1'b0;
    end else begin
      done_q   <= accept;
      missed_q <= frm_done_i && !accept;
      if (accept) idx_q <= cur_link_i;
      if (rx_off_i)                run_q <= 1'b0;
      else if (rx_on_i)            run_q <= 1'b1;
      else if (run_q && cur_own_i) run_q <= 1'b0;  // ring full: stall
    end
  end

  assign eng_we_o    = accept;
  assign cur_idx_o   = idx_q;
  assign run_o       = run_q;
  assign desc_done_o = done_q;
  assign missed_o    = missed_q;

  a_r3_off_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_off_i |=> !run_o);
  a_r3_on_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_on_i && !rx_off_i) |=> run_o);
  a_r8_stall_on_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && cur_own_i && !rx_on_i) |=> !run_o);
  a_r9_idle_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_done_i && !run_o) |=> missed_o && !desc_done_o && $stable(cur_idx_o));
  a_r7_follow_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we_o |=> cur_idx_o == $past(cur_link_i));
  a_r4_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(desc_done_o && missed_o));
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rx_ring_pkg::*;
#(
  parameter int unsigned N_DESC = 4,
  parameter int unsigned LEN_W  = 16,  // must be >= 12
  localparam int unsigned IDX_W = $clog2(N_DESC > 1 ? N_DESC : 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [IDX_W-1:0]  host_idx_i,
  input  logic [1:0]        host_word_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  input  logic              rx_on_i,
  input  logic              rx_off_i,
  input  logic              frm_done_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  input  logic              frm_err_i,
  input  logic              frm_more_i,
  output logic              run_o,
  output logic [IDX_W-1:0]  cur_idx_o,
  output logic              desc_done_o,
  output logic              missed_o
);
  logic              eng_we;
  logic [WORD_W-1:0] eng_cmdsts;
  logic [IDX_W-1:0]  cur_link;
  logic              cur_own, cur_intr;
  logic [SIZE_W-1:0] cur_size;

  rx_desc_file #(.N_DESC(N_DESC), .IDX_W(IDX_W)) u_file (
    .clk_i, .rst_ni,
    .host_we_i, .host_idx_i, .host_word_i, .host_wdata_i, .host_rdata_o,
    .eng_we_i(eng_we), .eng_idx_i(cur_idx_o), .eng_cmdsts_i(eng_cmdsts),
    .cur_idx_i(cur_idx_o), .cur_link_o(cur_link), .cur_own_o(cur_own),
    .cur_intr_o(cur_intr), .cur_size_o(cur_size)
  );

  rx_ring_ctrl #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni, .rx_on_i, .rx_off_i,
    .frm_done_i, .frm_len_i, .frm_err_i, .frm_more_i,
    .cur_link_i(cur_link), .cur_own_i(cur_own), .cur_intr_i(cur_intr),
    .cur_size_i(cur_size), .cur_idx_o, .eng_we_o(eng_we),
    .eng_cmdsts_o(eng_cmdsts), .run_o, .desc_done_o, .missed_o
  );
endmodule

// File: tb/rx_ring_engine_test.sv
module rx_ring_engine_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_idx = '0, host_word = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        rx_on = 1'b0, rx_off = 1'b0;
  logic        frm_done = 1'b0, frm_err = 1'b0, frm_more = 1'b0;
  logic [15:0] frm_len = '0;
  logic        run, done, missed;
  logic [1:0]  cur_idx;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rx_ring_engine uut (
    .clk_i(clk), .rst_ni, .host_we_i(host_we), .host_idx_i(host_idx),
    .host_word_i(host_word), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .rx_on_i(rx_on), .rx_off_i(rx_off), .frm_done_i(frm_done), .frm_len_i(frm_len),
    .frm_err_i(frm_err), .frm_more_i(frm_more), .run_o(run), .cur_idx_o(cur_idx),
    .desc_done_o(done), .missed_o(missed)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, input int word, output logic [31:0] v);
    host_idx = 2'(idx); host_word = 2'(word); #1; v = host_rdata;
  endtask

  task automatic wr(input int idx, input int word, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_idx = 2'(idx); host_word = 2'(word); host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic cmd(input logic on, input logic off);
    @(negedge clk); rx_on = on; rx_off = off;
    @(negedge clk); rx_on = 0; rx_off = 0;
  endtask

  task automatic send(input int len, input logic err, input logic more);
    @(negedge clk); frm_done = 1; frm_len = 16'(len); frm_err = err; frm_more = more;
    @(negedge clk); frm_done = 0; frm_err = 0; frm_more = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 run", 32'(run), 0);
    check("R1 idx", 32'(cur_idx), 0);
    for (int i = 0; i < 4; i++) begin
      rd(i, 0, v); check("R1 link", v, 32'((i + 1) % 4));
      rd(i, 1, v); check("R1 cmdsts", v, 32'h600);
      rd(i, 2, v); check("R1 bufptr", v, 32'(i * 1536));
      rd(i, 3, v); check("R2 word3", v, 0);
    end
  endtask

  task automatic t_idle_drop;
    logic [31:0] v;
    send(64, 0, 0);
    check("R9 missed", 32'(missed), 1);
    check("R9 no done", 32'(done), 0);
    check("R9 idx", 32'(cur_idx), 0);
    rd(0, 1, v); check("R9 desc0 untouched", v, 32'h600);
  endtask

  task automatic t_fill_ring;
    logic [31:0] v;
    cmd(1, 0);
    check("R3 on", 32'(run), 1);
    send(64, 0, 0);
    check("R4 done", 32'(done), 1);
    rd(0, 1, v); check("R4 clean", v, 32'h8800_0040);
    check("R7 idx1", 32'(cur_idx), 1);
    send(100, 1, 0);
    rd(1, 1, v); check("R5 err clears good", v, 32'h8000_0064);
    send(200, 0, 1);
    rd(2, 1, v); check("R5 more", v, 32'hC800_00C8);
    send(2000, 0, 0);
    rd(3, 1, v); check("R6 too long", v, 32'h8040_0600);
    check("R7 wrap", 32'(cur_idx), 0);
    check("R8 still running", 32'(run), 1);
    @(negedge clk);
    check("R8 stalled", 32'(run), 0);
  endtask

  task automatic t_stalled_drop;
    logic [31:0] v;
    send(70, 0, 0);
    check("R8 missed", 32'(missed), 1);
    rd(0, 1, v); check("R8 desc0 kept", v, 32'h8800_0040);
    check("R8 idx", 32'(cur_idx), 0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(0, 1, 32'h600);
    cmd(1, 0);
    check("R10 run", 32'(run), 1);
    send(60, 0, 0);
    rd(0, 1, v); check("R10 same idx", v, 32'h8800_003C);
    @(negedge clk);
    check("R8 stall desc1", 32'(run), 0);
  endtask

  task automatic t_word3;
    logic [31:0] v;
    wr(2, 3, 32'hDEAD_BEEF);
    rd(2, 3, v); check("R2 word3 read", v, 0);
    rd(2, 0, v); check("R2 link kept", v, 3);
    rd(2, 2, v); check("R2 bufptr kept", v, 32'(2 * 1536));
    wr(2, 2, 32'h0001_2340);
    rd(2, 2, v); check("R2 bufptr write", v, 32'h0001_2340);
  endtask

  task automatic t_intr_clamp;
    logic [31:0] v;
    wr(1, 1, 32'h2000_0100);
    wr(2, 1, 32'h600);
    wr(3, 1, 32'h600);
    cmd(1, 0);
    send(300, 0, 0);
    rd(1, 1, v); check("R5 R6 intr kept, clamp 256", v, 32'hA040_0100);
    check("R7 idx2", 32'(cur_idx), 2);
  endtask

  task automatic t_off;
    logic [31:0] v;
    cmd(0, 1);
    check("R3 off", 32'(run), 0);
    send(90, 0, 0);
    check("R9 missed after off", 32'(missed), 1);
    rd(2, 1, v); check("R9 desc2 kept", v, 32'h600);
    cmd(1, 1);
    check("R3 off wins", 32'(run), 0);
  endtask

  task automatic t_custom_link;
    logic [31:0] v;
    wr(0, 1, 32'h600);
    wr(1, 1, 32'h600);
    wr(2, 0, 32'h0);
    cmd(1, 0);
    send(128, 0, 0);
    rd(2, 1, v); check("R4 desc2", v, 32'h8800_0080);
    check("R7 custom link", 32'(cur_idx), 0);
    check("R7 running", 32'(run), 1);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    @(negedge clk);
    host_we = 1; host_idx = 0; host_word = 1; host_wdata = 32'h600;
    frm_done = 1; frm_len = 80;
    @(negedge clk);
    host_we = 0; frm_done = 0;
    check("R11 done", 32'(done), 1);
    rd(0, 1, v); check("R11 engine wins", v, 32'h8800_0050);
    check("R7 idx1", 32'(cur_idx), 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", checks);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_drop();
    t_fill_ring();
    t_stalled_drop();
    t_restart();
    t_word3();
    t_intr_clamp();
    t_off();
    t_custom_link();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule